// File: doc/BRIEF.md
# Multiplexed Bidirectional Latching Bus Exchanger

This block joins one wide port, A, to two ports of the same width, 1B and 2B. It lets two independent data paths share one path, as when address and data share a bus or when two memory banks are interleaved. Going from A to B, the value on A enters two separate storage banks, one for each B port. Each bank drives its own B port under its own output enable, so one B port, both or neither can be driven. Going from B to A, each B port has a storage bank of its own. A select input decides which of the two stored values appears on A.

Every storage bank acts as a transparent latch inside a clocked design. While the bank's load enable is high, its output follows its input in the same cycle. The input value is also written into the bank on each rising clock edge during that time. Once the enable is low, the bank keeps the value it wrote at the last rising edge where the enable was high. Each port has a separate input vector, an output vector and an active-high drive flag. A parent level can turn these into a tri-state pad if it needs one. A synchronous reset clears all four banks.

Top module: `bus_exchanger`

## Requirements
- R1: While `leToB1` is high, `b1Out` equals `aIn` in the same cycle. In the same way, while `leToB2` is high, `b2Out` equals `aIn`. This applies whenever the port is driving.
- R2: After an A-to-B load enable goes low, the matching B output holds the `aIn` value that was present at the last rising clock edge where that enable was high. Later changes on `aIn` do not affect it.
- R3: The two A-to-B banks are independent. Loading the 1B bank leaves `b2Out` unchanged, and loading the 2B bank leaves `b1Out` unchanged.
- R4: The B-to-A banks behave like R1 and R2, with their own enables. The bank loaded by `leFromB1` takes `b1In`, and the bank loaded by `leFromB2` takes `b2In`. Each is transparent while its enable is high and holds its value while the enable is low.
- R5: When `selB1` is 1, `aOut` shows the 1B return bank. When `selB1` is 0, `aOut` shows the 2B return bank.
- R6: The return bank that is not selected keeps its stored value. Selecting it later shows that value on `aOut`.
- R7: The output enables `oeAN`, `oeB1N` and `oeB2N` are active low. Each drive flag equals the inverse of its enable. While a port is not driving, its output vector is all zeros.
- R8: While `rstSync` is high, a rising clock edge clears all four banks to 0. A bank that has not been loaded since reset then reads 0 on its port.
- R9: Driving A and both B ports at the same time is legal. All three paths work at once without interfering with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous reset; clears all banks |
| aIn | input | WIDTH | Data arriving on port A |
| b1In | input | WIDTH | Data arriving on port 1B |
| b2In | input | WIDTH | Data arriving on port 2B |
| leToB1 | input | 1 | Load enable of the A-to-1B bank |
| leToB2 | input | 1 | Load enable of the A-to-2B bank |
| leFromB1 | input | 1 | Load enable of the 1B-to-A bank |
| leFromB2 | input | 1 | Load enable of the 2B-to-A bank |
| selB1 | input | 1 | 1 routes the 1B return bank to A; 0 routes the 2B return bank |
| oeAN | input | 1 | Active-low output enable of port A |
| oeB1N | input | 1 | Active-low output enable of port 1B |
| oeB2N | input | 1 | Active-low output enable of port 2B |
| aOut | output | WIDTH | Data driven onto port A |
| aDrive | output | 1 | High when port A is driving |
| b1Out | output | WIDTH | Data driven onto port 1B |
| b1Drive | output | 1 | High when port 1B is driving |
| b2Out | output | WIDTH | Data driven onto port 2B |
| b2Drive | output | 1 | High when port 2B is driving |

## Verification
A bank that stored the wrong value, or that lost its value, shows on its port as soon as the port drives while its enable is low. The bench checks this in the cycle after the enable falls and again one clock later. A load strobe sent to the wrong bank shows as a change on the neighbouring port, which should have stayed unchanged, in the cycle straight after the load edge. An inverted select, or a select that looks at the wrong bank, shows on `aOut` in the same cycle `selB1` changes, because the bench has first loaded the two return banks with different values.

// File: rtl/bus_exchanger_pkg.sv
package bus_exchanger_pkg;

  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_TO_B1 = 0;
  localparam int unsigned BANK_TO_B2 = 1;
  localparam int unsigned BANK_FROM_B1 = 2;
  localparam int unsigned BANK_FROM_B2 = 3;

  typedef struct packed {
    logic                 clear;
    logic [NUM_BANKS-1:0] load;
    logic                 pickB1;
    logic                 driveA;
    logic                 driveB1;
    logic                 driveB2;
  } xchg_strobes_t;

endpackage

// File: rtl/bus_exchanger_ctrl.sv
module bus_exchanger_ctrl
  import bus_exchanger_pkg::*;
(
  input  logic          rstSync,
  input  logic          leToB1,
  input  logic          leToB2,
  input  logic          leFromB1,
  input  logic          leFromB2,
  input  logic          selB1,
  input  logic          oeAN,
  input  logic          oeB1N,
  input  logic          oeB2N,
  output xchg_strobes_t strobes
);

  always_comb begin
    strobes = '0;
    strobes.clear = rstSync;
    strobes.load[BANK_TO_B1] = leToB1;
    strobes.load[BANK_TO_B2] = leToB2;
    strobes.load[BANK_FROM_B1] = leFromB1;
    strobes.load[BANK_FROM_B2] = leFromB2;
    strobes.pickB1 = selB1;
    strobes.driveA = ~oeAN;
    strobes.driveB1 = ~oeB1N;
    strobes.driveB2 = ~oeB2N;
  end

endmodule

// File: rtl/bus_exchanger_cell.sv
module bus_exchanger_cell #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] held;

  always_ff @(posedge clk) begin
    if (clear) begin
      held <= '0;
    end else if (load) begin
      held <= dIn;
    end
  end

  // transparent while open, stored value while closed
  assign qOut = load ? dIn : held;

endmodule

// File: rtl/bus_exchanger_datapath.sv
module bus_exchanger_datapath
  import bus_exchanger_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  xchg_strobes_t    strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] b1In,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] b1Out,
  output logic [WIDTH-1:0] b2Out
);

  logic [NUM_BANKS-1:0][WIDTH-1:0] bankIn;
  logic [NUM_BANKS-1:0][WIDTH-1:0] bankOut;
  logic [WIDTH-1:0] returnPick;

  always_comb begin
    bankIn[BANK_TO_B1] = aIn;
    bankIn[BANK_TO_B2] = aIn;
    bankIn[BANK_FROM_B1] = b1In;
    bankIn[BANK_FROM_B2] = b2In;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bus_exchanger_cell #(.WIDTH(WIDTH)) u_cell (
      .clk  (clk),
      .clear(strobes.clear),
      .load (strobes.load[g]),
      .dIn  (bankIn[g]),
      .qOut (bankOut[g])
    );
  end

  assign returnPick = strobes.pickB1 ? bankOut[BANK_FROM_B1] : bankOut[BANK_FROM_B2];

  assign aOut  = strobes.driveA  ? returnPick          : '0;
  assign b1Out = strobes.driveB1 ? bankOut[BANK_TO_B1] : '0;
  assign b2Out = strobes.driveB2 ? bankOut[BANK_TO_B2] : '0;

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bus_exchanger_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstSync,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] b1In,
  input  logic [WIDTH-1:0] b2In,
  input  logic             leToB1,
  input  logic             leToB2,
  input  logic             leFromB1,
  input  logic             leFromB2,
  input  logic             selB1,
  input  logic             oeAN,
  input  logic             oeB1N,
  input  logic             oeB2N,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  output logic [WIDTH-1:0] b1Out,
  output logic             b1Drive,
  output logic [WIDTH-1:0] b2Out,
  output logic             b2Drive
);

  xchg_strobes_t strobes;

  bus_exchanger_ctrl u_ctrl (
    .rstSync (rstSync),
    .leToB1  (leToB1),
    .leToB2  (leToB2),
    .leFromB1(leFromB1),
    .leFromB2(leFromB2),
    .selB1   (selB1),
    .oeAN    (oeAN),
    .oeB1N   (oeB1N),
    .oeB2N   (oeB2N),
    .strobes (strobes)
  );

  bus_exchanger_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .strobes(strobes),
    .aIn    (aIn),
    .b1In   (b1In),
    .b2In   (b2In),
    .aOut   (aOut),
    .b1Out  (b1Out),
    .b2Out  (b2Out)
  );

  assign aDrive  = strobes.driveA;
  assign b1Drive = strobes.driveB1;
  assign b2Drive = strobes.driveB2;

endmodule

// File: rtl/bus_exchanger_checker.sv
module bus_exchanger_checker #(
  parameter int unsigned WIDTH = 12
) (
  input logic             clk,
  input logic             rstSync,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] b1In,
  input logic             leToB1,
  input logic             leFromB1,
  input logic             selB1,
  input logic             oeAN,
  input logic             oeB1N,
  input logic [WIDTH-1:0] aOut,
  input logic             aDrive,
  input logic [WIDTH-1:0] b1Out
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rstSync) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_transparent_r1: assert property (@(posedge clk) disable iff (rstSync)
    (leToB1 && !oeB1N) |-> (b1Out == aIn));

  p_hold_r2: assert property (@(posedge clk) disable iff (rstSync)
    (armed && !leToB1 && $past(!leToB1) && $past(!rstSync) && !oeB1N && $past(!oeB1N))
      |-> $stable(b1Out));

  p_select_r5: assert property (@(posedge clk) disable iff (rstSync)
    (!oeAN && leFromB1 && selB1) |-> (aOut == b1In));

  p_quiet_r7: assert property (@(posedge clk) disable iff (rstSync)
    !aDrive |-> (aOut == '0));

  p_cleared_r8: assert property (@(posedge clk) disable iff (rstSync)
    ($past(rstSync) && !leToB1 && !oeB1N) |-> (b1Out == '0));

endmodule

bind bus_exchanger bus_exchanger_checker #(.WIDTH(WIDTH)) u_checker (
  .clk     (clk),
  .rstSync (rstSync),
  .aIn     (aIn),
  .b1In    (b1In),
  .leToB1  (leToB1),
  .leFromB1(leFromB1),
  .selB1   (selB1),
  .oeAN    (oeAN),
  .oeB1N   (oeB1N),
  .aOut    (aOut),
  .aDrive  (aDrive),
  .b1Out   (b1Out)
);

// File: tb/bus_exchanger_bench.sv
module bus_exchanger_bench;

  localparam int WIDTH = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstSync;
  logic [WIDTH-1:0] aIn, b1In, b2In;
  logic leToB1, leToB2, leFromB1, leFromB2, selB1;
  logic oeAN, oeB1N, oeB2N;
  logic [WIDTH-1:0] aOut, b1Out, b2Out;
  logic aDrive, b1Drive, b2Drive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_exchanger #(.WIDTH(WIDTH)) u_bus_exchanger (
    .clk(clk), .rstSync(rstSync), .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .leToB1(leToB1), .leToB2(leToB2), .leFromB1(leFromB1), .leFromB2(leFromB2),
    .selB1(selB1), .oeAN(oeAN), .oeB1N(oeB1N), .oeB2N(oeB2N),
    .aOut(aOut), .aDrive(aDrive), .b1Out(b1Out), .b1Drive(b1Drive),
    .b2Out(b2Out), .b2Drive(b2Drive)
  );

  task automatic check(input string req, input string what,
                       input logic [WIDTH-1:0] actual, input logic [WIDTH-1:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, actual, expected);
    end
  endtask

  // one clock edge, then settle past the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic test_reset();
    rstSync = 1'b1;
    aIn = 12'h5A5; b1In = 12'h3C3; b2In = 12'h0F0;
    {leToB1, leToB2, leFromB1, leFromB2} = '0;
    selB1 = 1'b1; oeAN = 1'b0; oeB1N = 1'b0; oeB2N = 1'b0;
    step(); step();
    rstSync = 1'b0;
    settle();
    check("R8", "b1Out after reset", b1Out, '0);
    check("R8", "b2Out after reset", b2Out, '0);
    check("R8", "aOut sel 1B after reset", aOut, '0);
    selB1 = 1'b0; settle();
    check("R8", "aOut sel 2B after reset", aOut, '0);
    check("R7", "drive flags enabled", {9'b0, aDrive, b1Drive, b2Drive}, 12'h007);
  endtask

  task automatic test_enables();
    leToB1 = 1'b1; aIn = 12'h777;
    oeAN = 1'b1; oeB1N = 1'b1; oeB2N = 1'b1;
    settle();
    check("R7", "drive flags off", {9'b0, aDrive, b1Drive, b2Drive}, 12'h000);
    check("R7", "b1Out zero when disabled", b1Out, '0);
    check("R7", "aOut zero when disabled", aOut, '0);
    oeB1N = 1'b0; settle();
    check("R7", "only b1 drives", {9'b0, aDrive, b1Drive, b2Drive}, 12'h002);
    check("R7", "b1Out follows when enabled", b1Out, 12'h777);
    leToB1 = 1'b0;
    step();
    oeAN = 1'b0; oeB2N = 1'b0;
    settle();
  endtask

  task automatic test_a_to_b();
    leToB1 = 1'b1; aIn = 12'hABC; settle();
    check("R1", "b1Out transparent", b1Out, 12'hABC);
    check("R3", "b2Out untouched during 1B load", b2Out, '0);
    aIn = 12'hABD; settle();
    check("R1", "b1Out follows change", b1Out, 12'hABD);
    step();
    leToB1 = 1'b0; aIn = 12'h123; settle();
    check("R2", "b1Out holds after close", b1Out, 12'hABD);
    step();
    check("R2", "b1Out holds next cycle", b1Out, 12'hABD);
    leToB2 = 1'b1; aIn = 12'h555; settle();
    check("R1", "b2Out transparent", b2Out, 12'h555);
    step();
    leToB2 = 1'b0; aIn = 12'h999; settle();
    check("R2", "b2Out holds", b2Out, 12'h555);
    check("R3", "b1Out untouched by 2B load", b1Out, 12'hABD);
  endtask

  task automatic test_b_to_a();
    selB1 = 1'b1; leFromB1 = 1'b1; b1In = 12'h111; settle();
    check("R4", "aOut transparent from 1B", aOut, 12'h111);
    check("R5", "sel=1 shows 1B path", aOut, 12'h111);
    step();
    leFromB1 = 1'b0; b1In = 12'hEEE; settle();
    check("R4", "1B return bank holds", aOut, 12'h111);
    selB1 = 1'b0; leFromB2 = 1'b1; b2In = 12'h222; settle();
    check("R5", "sel=0 shows 2B path", aOut, 12'h222);
    step();
    leFromB2 = 1'b0; b2In = 12'hDDD; settle();
    check("R4", "2B return bank holds", aOut, 12'h222);
    selB1 = 1'b1; settle();
    check("R6", "unselected 1B bank kept value", aOut, 12'h111);
    step();
    selB1 = 1'b0; settle();
    check("R6", "2B bank kept value while unselected", aOut, 12'h222);
  endtask

  task automatic test_all_at_once();
    {leToB1, leToB2, leFromB1, leFromB2} = 4'hF;
    selB1 = 1'b1; aIn = 12'hAAA; b1In = 12'hBBB; b2In = 12'hCCC;
    settle();
    check("R9", "b1Out with all paths active", b1Out, 12'hAAA);
    check("R9", "b2Out with all paths active", b2Out, 12'hAAA);
    check("R9", "aOut with all paths active", aOut, 12'hBBB);
    step();
    {leToB1, leToB2, leFromB1, leFromB2} = 4'h0;
    aIn = 12'h000; b1In = 12'h000; b2In = 12'h000; selB1 = 1'b0; settle();
    check("R9", "aOut holds 2B value after joint load", aOut, 12'hCCC);
    check("R9", "b2Out holds after joint load", b2Out, 12'hAAA);
  endtask

  task automatic test_midrun_reset();
    rstSync = 1'b1;
    step();
    rstSync = 1'b0; settle();
    check("R8", "b1Out cleared mid-run", b1Out, '0);
    check("R8", "b2Out cleared mid-run", b2Out, '0);
    check("R8", "2B return bank cleared", aOut, '0);
    selB1 = 1'b1; settle();
    check("R8", "1B return bank cleared", aOut, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    test_reset();
    test_enables();
    test_a_to_b();
    test_b_to_a();
    test_all_at_once();
    test_midrun_reset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule